// File: doc/BRIEF.md
# Chainable Performance Counter Bank

This block is a bank of event counters that sits behind a simple word-addressed register bus. Each counter picks one of 256 event strobes through an 8-bit selector. It advances by one on every cycle in which its selected strobe is high, as long as the counter is individually enabled and the bank-wide run bit is set. Software starts and stops counters with write-1-to-set and write-1-to-clear masks. It reads and writes each count directly. It collects wrap events from a sticky status word that is cleared by writing ones.

Two counters of an adjacent pair can act as one wide counter. When chaining is turned on for the odd member of a pair, the odd counter stops looking at its own selector and advances once each time its even partner rolls over from all ones to zero. A per-counter option redefines overflow as any change of the counter's top bit. This lets a free-running counter report each half-range crossing. A single level interrupt combines the status bits with per-counter interrupt enables.

Bus reads return data one cycle after the request. Writes take effect at the clock edge where they are presented.

Top module: `perf_counter_bank`

## Requirements
- R1: After the synchronous reset all counts, event selectors, counter enables, interrupt enables, chain bits, top-bit-mode bits and overflow status read as zero, the run bit reads 0 and `irq` is low.
- R2: An enabled counter advances by exactly one in each cycle in which the run bit is set and its selected strobe is high. Selector code 0x00 never advances it, and selector code 0x01 advances it on every cycle regardless of the strobes. Any other code N follows `evt_strobe[N]`.
- R3: The run bit is bit 0 of the control word at address 0x00. While it is 0, no counter changes except by a software write.
- R4: Address 0x01 sets and address 0x02 clears counter enables, where bit i stands for counter i. Zero bits in the written data leave the matching enables unchanged, and both addresses read back the current enable mask.
- R5: Addresses 0x03 and 0x04 set and clear the interrupt enables in the same way, where bit i stands for counter i. Both addresses read back the current interrupt enable mask.
- R6: The chain word at address 0x05 has bit i for counter i, and only odd bits are stored. Even bits read 0. While the bit of odd counter i is set, that counter advances only when counter i-1 rolls over from 0xFFFFFFFF to 0 in the same cycle, and its own selector is ignored.
- R7: When a counter advances from 0xFFFFFFFF to 0 with its top-bit mode clear, bit i of the overflow word at address 0x07 becomes 1. The bit stays 1 until software writes 1 to it. A new overflow in the same cycle as a clear leaves the bit set.
- R8: The top-bit-mode word at address 0x06 has bit i for counter i. While bit i is set, the counter's overflow bit is set whenever an advance changes bit 31 of the count in either direction, and only then.
- R9: `irq` is high exactly when some counter has both its overflow bit and its interrupt enable set.
- R10: Count i is read and written at address 0x10+i. A write there loads the written value even if an advance would have happened in the same cycle.
- R11: Writing 1 to bit 1 of the control word clears all counts, selectors, enables, interrupt enables, chain bits, top-bit-mode bits and overflow status in that cycle. The run bit takes bit 0 of the same write.
- R12: The selector of counter i is read and written at address 0x18+i in bits 7:0. A read at any address presented with `bus_rd` is returned on `bus_rdata` after the next clock edge, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_rd | input | 1 | Read request for the addressed register |
| bus_addr | input | ADDR_W (8) | Word address |
| bus_wdata | input | CNT_W (32) | Write data |
| bus_rdata | output | CNT_W (32) | Registered read data, valid the cycle after `bus_rd` |
| evt_strobe | input | 2**EVT_W (256) | Event strobes, one bit per selector code |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives a counter across the all-ones boundary while its odd partner is chained. A design that failed to propagate the carry, or that still obeyed the odd counter's own selector, would return a wrong upper word. Top-bit mode is tested both rising through 0x7FFFFFFF and wrapping through 0xFFFFFFFF. A design that only checked wrap would miss the first status bit. The bench also writes zeros to the set and clear masks and writes ones to the even chain bits; both must leave stored state alone. A soft reset in the middle of counting must clear everything except the run bit taken from that same write. The interrupt level is compared on every clock against a behavioural model, so an enable gating error shows up the cycle it happens.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  // Control-side word addresses; the order fixes the register map
  typedef enum logic [2:0] {
    RG_CTRL  = 3'd0,
    RG_ENSET = 3'd1,
    RG_ENCLR = 3'd2,
    RG_IESET = 3'd3,
    RG_IECLR = 3'd4,
    RG_CHAIN = 3'd5,
    RG_MSB   = 3'd6,
    RG_OVF   = 3'd7
  } ctrl_reg_e;

  // Base word addresses of the per-counter windows
  localparam int CNT_BASE = 16;

  // Selector codes with fixed meaning
  localparam int EV_NONE   = 0;
  localparam int EV_CYCLES = 1;

  // Control word bit positions
  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_SRST_BIT = 1;

endpackage

// File: rtl/pcb_slice.sv
module pcb_slice #(
  parameter int CNT_W = 32,
  parameter int EVT_W = 8,
  localparam int NUM_EVT = 2 ** EVT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               srst,
  input  logic               run,
  input  logic               chain_on,
  input  logic               carry_in,
  input  logic [NUM_EVT-1:0] evt_strobe,
  input  logic               cnt_we,
  input  logic               sel_we,
  input  logic [CNT_W-1:0]   wdata,
  output logic [CNT_W-1:0]   cnt_q,
  output logic [EVT_W-1:0]   sel_q,
  output logic               wrap_pulse,
  output logic               msb_pulse
);

  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  logic evt_hit;
  logic src;
  logic inc;

  always_comb begin
    if (sel_q == EVT_W'(pcb_pkg::EV_NONE))        evt_hit = 1'b0;
    else if (sel_q == EVT_W'(pcb_pkg::EV_CYCLES)) evt_hit = 1'b1;
    else                                          evt_hit = evt_strobe[sel_q];
  end

  // chained odd counters take the partner's carry instead of the event
  assign src        = chain_on ? carry_in : evt_hit;
  assign inc        = run & src & ~cnt_we & ~srst;
  assign wrap_pulse = inc & (cnt_q == ALL_ONES);
  assign msb_pulse  = inc & (&cnt_q[CNT_W-2:0]);

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else begin
      if (cnt_we)   cnt_q <= wdata;
      else if (inc) cnt_q <= cnt_q + CNT_W'(1);
      if (sel_we)   sel_q <= wdata[EVT_W-1:0];
    end
  end

  a_r3_frozen: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_we && !srst) |=> (cnt_q == $past(cnt_q)));

  a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
    (cnt_we && !srst) |=> (cnt_q == $past(wdata)));

  a_r6_chain_ignores_select: assert property (@(posedge clk) disable iff (rst)
    (chain_on && !carry_in && !cnt_we && !srst) |=> (cnt_q == $past(cnt_q)));

  a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
    (!cnt_we && !srst) |=>
      ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1))));

endmodule

// File: rtl/pcb_ctrl.sv
module pcb_ctrl #(
  parameter int NUM_CNT = 8,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_CNT-1:0] wdata,
  input  logic [NUM_CNT-1:0] wrap_pulse,
  input  logic [NUM_CNT-1:0] msb_pulse,
  output logic               srst,
  output logic               master,
  output logic [NUM_CNT-1:0] en_q,
  output logic [NUM_CNT-1:0] ie_q,
  output logic [NUM_CNT-1:0] chain_q,
  output logic [NUM_CNT-1:0] msb_q,
  output logic [NUM_CNT-1:0] ovf_q,
  output logic               irq
);
  import pcb_pkg::*;

  function automatic logic [NUM_CNT-1:0] odd_bits();
    logic [NUM_CNT-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_CNT; i++) m[i] = ((i % 2) == 1);
    return m;
  endfunction

  localparam logic [NUM_CNT-1:0] ODD_MASK = odd_bits();

  logic               hit_ctrl, hit_enset, hit_enclr, hit_ieset, hit_ieclr;
  logic               hit_chain, hit_msb, hit_ovf;
  logic [NUM_CNT-1:0] ovf_set, ovf_clr;

  assign hit_ctrl  = wr && (addr == ADDR_W'(RG_CTRL));
  assign hit_enset = wr && (addr == ADDR_W'(RG_ENSET));
  assign hit_enclr = wr && (addr == ADDR_W'(RG_ENCLR));
  assign hit_ieset = wr && (addr == ADDR_W'(RG_IESET));
  assign hit_ieclr = wr && (addr == ADDR_W'(RG_IECLR));
  assign hit_chain = wr && (addr == ADDR_W'(RG_CHAIN));
  assign hit_msb   = wr && (addr == ADDR_W'(RG_MSB));
  assign hit_ovf   = wr && (addr == ADDR_W'(RG_OVF));

  assign srst    = hit_ctrl && wdata[CTRL_SRST_BIT];
  assign ovf_set = (msb_q & msb_pulse) | (~msb_q & wrap_pulse);
  assign ovf_clr = hit_ovf ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      master  <= 1'b0;
      en_q    <= '0;
      ie_q    <= '0;
      chain_q <= '0;
      msb_q   <= '0;
      ovf_q   <= '0;
    end else if (srst) begin
      master  <= wdata[CTRL_RUN_BIT];
      en_q    <= '0;
      ie_q    <= '0;
      chain_q <= '0;
      msb_q   <= '0;
      ovf_q   <= '0;
    end else begin
      if (hit_ctrl)  master  <= wdata[CTRL_RUN_BIT];
      if (hit_enset) en_q    <= en_q | wdata;
      if (hit_enclr) en_q    <= en_q & ~wdata;
      if (hit_ieset) ie_q    <= ie_q | wdata;
      if (hit_ieclr) ie_q    <= ie_q & ~wdata;
      if (hit_chain) chain_q <= wdata & ODD_MASK;
      if (hit_msb)   msb_q   <= wdata;
      ovf_q <= (ovf_q & ~ovf_clr) | ovf_set;
    end
  end

  assign irq = |(ovf_q & ie_q);

  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    !srst |=> (($past(ovf_q) & ~$past(ovf_clr) & ~ovf_q) == '0));

  a_r9_irq_needs_source: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((ie_q != '0) && (ovf_q != '0)));

  a_r4_set_never_clears: assert property (@(posedge clk) disable iff (rst)
    (hit_enset && !srst) |=> ((en_q & $past(en_q)) == $past(en_q)));

endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank #(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 32,
  parameter int EVT_W   = 8,
  parameter int ADDR_W  = 8,
  localparam int NUM_EVT = 2 ** EVT_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [CNT_W-1:0]   bus_wdata,
  output logic [CNT_W-1:0]   bus_rdata,
  input  logic [NUM_EVT-1:0] evt_strobe,
  output logic               irq
);
  import pcb_pkg::*;

  localparam int SEL_BASE = CNT_BASE + NUM_CNT;

  logic               srst, master;
  logic [NUM_CNT-1:0] en_q, ie_q, chain_q, msb_q, ovf_q;
  logic [NUM_CNT-1:0] wrap_pulse, msb_pulse;
  logic [NUM_CNT-1:0] chain_on, carry_in;
  logic [CNT_W-1:0]   cnt_arr [NUM_CNT];
  logic [EVT_W-1:0]   sel_arr [NUM_CNT];
  logic [CNT_W-1:0]   rd_word;

  pcb_ctrl #(.NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr         (bus_wr),
    .addr       (bus_addr),
    .wdata      (bus_wdata[NUM_CNT-1:0]),
    .wrap_pulse (wrap_pulse),
    .msb_pulse  (msb_pulse),
    .srst       (srst),
    .master     (master),
    .en_q       (en_q),
    .ie_q       (ie_q),
    .chain_q    (chain_q),
    .msb_q      (msb_q),
    .ovf_q      (ovf_q),
    .irq        (irq)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    if ((g % 2) == 1) begin : g_odd
      assign chain_on[g] = chain_q[g];
      assign carry_in[g] = wrap_pulse[g-1];
    end else begin : g_even
      assign chain_on[g] = 1'b0;
      assign carry_in[g] = 1'b0;
    end

    pcb_slice #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_slice (
      .clk        (clk),
      .rst        (rst),
      .srst       (srst),
      .run        (master & en_q[g]),
      .chain_on   (chain_on[g]),
      .carry_in   (carry_in[g]),
      .evt_strobe (evt_strobe),
      .cnt_we     (bus_wr && (bus_addr == ADDR_W'(CNT_BASE + g))),
      .sel_we     (bus_wr && (bus_addr == ADDR_W'(SEL_BASE + g))),
      .wdata      (bus_wdata),
      .cnt_q      (cnt_arr[g]),
      .sel_q      (sel_arr[g]),
      .wrap_pulse (wrap_pulse[g]),
      .msb_pulse  (msb_pulse[g])
    );
  end

  always_comb begin
    rd_word = '0;
    case (bus_addr)
      ADDR_W'(RG_CTRL):  rd_word[0] = master;
      ADDR_W'(RG_ENSET),
      ADDR_W'(RG_ENCLR): rd_word[NUM_CNT-1:0] = en_q;
      ADDR_W'(RG_IESET),
      ADDR_W'(RG_IECLR): rd_word[NUM_CNT-1:0] = ie_q;
      ADDR_W'(RG_CHAIN): rd_word[NUM_CNT-1:0] = chain_q;
      ADDR_W'(RG_MSB):   rd_word[NUM_CNT-1:0] = msb_q;
      ADDR_W'(RG_OVF):   rd_word[NUM_CNT-1:0] = ovf_q;
      default: ;
    endcase
    for (int i = 0; i < NUM_CNT; i++) begin
      if (bus_addr == ADDR_W'(CNT_BASE + i)) rd_word = cnt_arr[i];
      if (bus_addr == ADDR_W'(SEL_BASE + i)) rd_word = CNT_W'(sel_arr[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

endmodule

// File: tb/test_perf_counter_bank.sv
`timescale 1ns/1ps
module test_perf_counter_bank;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [255:0] evt_strobe = '0;
  logic         irq;

  int total = 0, bad = 0;
  logic [31:0] lfsr = 32'hACE1_2468;
  bit          strobe_on = 1'b1;
  bit          rd_pend = 1'b0;
  string       rd_tag;
  logic [7:0]  rd_adr;

  // behavioural reference state
  logic [31:0] mcnt [8];
  logic [7:0]  msel [8];
  logic [7:0]  men, mie, mchain, mmsb, movf;
  logic        mmaster;
  logic [31:0] exp_rd;

  perf_counter_bank i_perf_counter_bank (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_strobe(evt_strobe), .irq(irq));

  always #2 clk = ~clk;

  function automatic logic [31:0] mread(input logic [7:0] a);
    if (a == 8'h00) return {31'd0, mmaster};
    if (a == 8'h01 || a == 8'h02) return {24'd0, men};
    if (a == 8'h03 || a == 8'h04) return {24'd0, mie};
    if (a == 8'h05) return {24'd0, mchain};
    if (a == 8'h06) return {24'd0, mmsb};
    if (a == 8'h07) return {24'd0, movf};
    if (a >= 8'h10 && a < 8'h18) return mcnt[a - 8'h10];
    if (a >= 8'h18 && a < 8'h20) return {24'd0, msel[a - 8'h18]};
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 8; i++) begin mcnt[i] = 0; msel[i] = 0; end
      men = 0; mie = 0; mchain = 0; mmsb = 0; movf = 0; mmaster = 0; exp_rd = 0;
    end else begin
      logic       srst, carry, hit, inc;
      logic [7:0] newovf;
      logic [31:0] old;
      if (bus_rd) exp_rd = mread(bus_addr);
      srst = bus_wr && bus_addr == 8'h00 && bus_wdata[1];
      carry = 0; newovf = 0;
      for (int i = 0; i < 8; i++) begin
        logic cnext;
        cnext = 0;
        if ((i % 2) == 1 && mchain[i]) hit = carry;
        else if (msel[i] == 0) hit = 0;
        else if (msel[i] == 1) hit = 1;
        else hit = evt_strobe[msel[i]];
        inc = men[i] && mmaster && hit;
        old = mcnt[i];
        if (srst) mcnt[i] = 0;
        else if (bus_wr && bus_addr == 8'(16 + i)) mcnt[i] = bus_wdata;
        else if (inc) begin
          mcnt[i] = old + 1;
          cnext = (old == 32'hFFFF_FFFF);
          if (mmsb[i] ? (old[31] != mcnt[i][31]) : cnext) newovf[i] = 1;
        end
        carry = ((i % 2) == 0) ? cnext : 1'b0;
      end
      if (srst) begin
        for (int i = 0; i < 8; i++) msel[i] = 0;
        men = 0; mie = 0; mchain = 0; mmsb = 0; movf = 0; mmaster = bus_wdata[0];
      end else begin
        logic [7:0] clr;
        clr = 0;
        if (bus_wr) begin
          case (bus_addr)
            8'h00: mmaster = bus_wdata[0];
            8'h01: men = men | bus_wdata[7:0];
            8'h02: men = men & ~bus_wdata[7:0];
            8'h03: mie = mie | bus_wdata[7:0];
            8'h04: mie = mie & ~bus_wdata[7:0];
            8'h05: mchain = bus_wdata[7:0] & 8'hAA;
            8'h06: mmsb = bus_wdata[7:0];
            8'h07: clr = bus_wdata[7:0];
            default: if (bus_addr >= 8'h18 && bus_addr < 8'h20) msel[bus_addr - 8'h18] = bus_wdata[7:0];
          endcase
        end
        movf = (movf & ~clr) | newovf;
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
    if (!rst) begin
      total++;
      if (irq !== |(movf & mie)) begin
        bad++;
        $display("FAIL R9 irq actual=%0b expected=%0b", irq, |(movf & mie));
      end
    end
    if (rd_pend) begin
      total++;
      if (bus_rdata !== exp_rd) begin
        bad++;
        $display("FAIL %s addr=0x%02h actual=0x%08h expected=0x%08h", rd_tag, rd_adr, bus_rdata, exp_rd);
      end
      rd_pend = 0;
    end
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    evt_strobe = strobe_on ? {8{lfsr}} : '0;
    bus_wr = 0; bus_rd = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d; step();
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    bus_rd = 1; bus_addr = a; rd_pend = 1; rd_tag = tag; rd_adr = a; step();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst = 1; idle(3); rst = 0;
    // R1: everything reads zero out of reset
    for (int a = 0; a < 8; a++) rd(8'(a), "R1");
    for (int a = 16; a < 32; a++) rd(8'(a), "R1");
    // R2 / R12: selectors, codes 0x20, 0x01, 0x00, 0x21
    wr(8'h18, 32'h20); wr(8'h19, 32'h01); wr(8'h1A, 32'h00); wr(8'h1B, 32'h21);
    for (int a = 24; a < 28; a++) rd(8'(a), "R12");
    wr(8'h00, 32'h1); wr(8'h01, 32'h0F);
    idle(30);
    for (int a = 16; a < 20; a++) rd(8'(a), "R2");
    // R4: zero writes do nothing, one bit clears
    wr(8'h01, 32'h0); rd(8'h01, "R4");
    wr(8'h02, 32'h08); rd(8'h01, "R4"); rd(8'h02, "R4");
    // R3: run bit off freezes counting
    wr(8'h00, 32'h0); idle(10);
    for (int a = 16; a < 19; a++) rd(8'(a), "R3");
    rd(8'h00, "R3");
    wr(8'h00, 32'h1);
    // R6: chain pair (0,1); even bits dropped
    wr(8'h10, 32'hFFFF_FFF0); wr(8'h11, 32'h5); wr(8'h05, 32'hFF);
    rd(8'h05, "R6");
    idle(60);
    rd(8'h11, "R6"); rd(8'h10, "R6");
    // R7 / R5 / R9: overflow status, interrupt enables, irq
    rd(8'h07, "R7");
    wr(8'h03, 32'h01); rd(8'h03, "R5"); idle(2);
    wr(8'h04, 32'h0); rd(8'h04, "R5");
    wr(8'h07, 32'h01); rd(8'h07, "R7");
    wr(8'h04, 32'h01); rd(8'h03, "R5");
    // R8: top-bit mode on counter 2 counting cycles
    wr(8'h1A, 32'h01); wr(8'h06, 32'h04); wr(8'h12, 32'h7FFF_FFFD);
    wr(8'h01, 32'h04); wr(8'h03, 32'h04);
    idle(6); rd(8'h07, "R8"); rd(8'h12, "R8");
    wr(8'h07, 32'hFF); wr(8'h12, 32'hFFFF_FFFD);
    idle(6); rd(8'h07, "R8"); rd(8'h06, "R8");
    // R10: a write beats a same-cycle advance
    wr(8'h12, 32'h0000_1234); rd(8'h12, "R10");
    wr(8'h12, 32'hDEAD_0000); rd(8'h12, "R10");
    // R12: unused address
    rd(8'h40, "R12");
    // R11: soft reset with run bit kept
    wr(8'h00, 32'h3);
    for (int a = 0; a < 8; a++) rd(8'(a), "R11");
    idle(5);
    for (int a = 16; a < 28; a++) rd(8'(a), "R11");
    idle(2);
    summary();
  end

endmodule